// File: doc/BRIEF.md
# Memory-Protection Security Control Register

This block is the machine-level security control register that sits beside a set of physical memory protection entries. It holds three control flags: a machine-mode lockdown flag (`mml`), a default-deny flag for machine-mode accesses that match no rule (`mmwp`), and a flag that lets software bypass the rule locks (`rlb`). Software reaches it through a plain write port (enable and data) and a combinational read port. The CSR address decode and the privilege checks are done upstream. The three flags are also driven out separately to the protection checker.

Both `mml` and `mmwp` can only be set. After either one is set, only a reset clears it. The `rlb` flag normally takes whatever value is written. There is one exception: if it reads 0 while any implemented protection entry is locked, it stays at 0. To decide this, the block scans the per-entry lock bits of the implemented entries. A lock that appears in the same cycle as the write already counts.

Each accepted write produces a one-cycle flush request, so that the translation and permission caches drop their contents. A build with no protection entries ignores every write.

Top module: `pmp_seccfg_reg`

## Requirements
- R1: After reset, `mml_o`, `mmwp_o`, `rlb_o`, `flush_o` and `rd_data_o` are all 0.
- R2: A write with data bit 0 set makes `mml_o` 1 from the next cycle on. After that, no write clears it, including a write with bit 0 at 0.
- R3: A write with data bit 1 set makes `mmwp_o` 1 from the next cycle on. After that, no write clears it, including a write with bit 1 at 0.
- R4: When no implemented entry is locked, a write loads data bit 2 into `rlb_o`, whether the bit is 0 or 1.
- R5: When `rlb_o` is 0 and at least one implemented entry has its lock bit set in the write cycle, `rlb_o` stays 0 whatever data bit 2 is.
- R6: When `rlb_o` is 1, a write loads data bit 2 into `rlb_o` even while entries are locked.
- R7: Lock bits at indices at or above `N_ENTRIES` have no effect on `rlb_o`.
- R8: The cycle after each accepted write, `flush_o` is 1 for exactly one cycle. In any other cycle it is 0.
- R9: When `N_ENTRIES` is 0, writes change nothing and raise no flush. All outputs stay 0.
- R10: `rd_data_o` bit 0 is `mml`, bit 1 is `mmwp` and bit 2 is `rlb`, all taken from the current register state. All higher bits read 0, and written values in bits 3 and up are dropped.
- R11: A cycle with no write leaves all three flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write data |
| entry_lock_i | input | 16 | Lock bit of each protection entry |
| rd_data_o | output | DATA_W | Current register value |
| mml_o | output | 1 | Machine-mode lockdown flag |
| mmwp_o | output | 1 | Default-deny flag for machine mode |
| rlb_o | output | 1 | Rule-lock bypass flag |
| flush_o | output | 1 | One-cycle cache flush request |

## Verification
The assertions assume that `wr_en_i` and `entry_lock_i` are valid at every rising edge once reset is released, and that they may change freely between edges. The assertions also assume that the lock vector the block receives is the one that is current in the write cycle. The stimulus drives all inputs only at falling edges and holds them steady across each rising edge. It changes the lock bits in the same cycle as a write so that the same-cycle lock case is covered, and it sets locks only above the implemented range so that R7 is covered.

// File: rtl/pmp_seccfg_pkg.sv
package pmp_seccfg_pkg;
  localparam int MAX_ENTRIES = 16;

  // Field order is fixed by the bit positions that software decodes.
  typedef struct packed {
    logic rlb;   // bit 2
    logic mmwp;  // bit 1
    logic mml;   // bit 0
  } seccfg_t;

  localparam int CFG_W = $bits(seccfg_t);

  // One bit per implemented entry; higher entries are masked off.
  function automatic logic [MAX_ENTRIES-1:0] impl_mask(input int n);
    logic [MAX_ENTRIES-1:0] m;
    m = '0;
    for (int i = 0; i < MAX_ENTRIES; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Next value of the register for an accepted write.
  function automatic seccfg_t seccfg_update(input seccfg_t cur,
                                            input logic [CFG_W-1:0] wdata,
                                            input logic locked);
    seccfg_t nxt;
    seccfg_t w;
    w        = seccfg_t'(wdata);
    nxt.mml  = cur.mml  | w.mml;
    nxt.mmwp = cur.mmwp | w.mmwp;
    nxt.rlb  = (!cur.rlb && locked) ? 1'b0 : w.rlb;
    return nxt;
  endfunction
endpackage

// File: rtl/pmp_lock_scan.sv
module pmp_lock_scan
  import pmp_seccfg_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  logic [MAX_ENTRIES-1:0] entry_lock_i,
  output logic                   any_locked_o
);
  localparam logic [MAX_ENTRIES-1:0] MASK = impl_mask(N_ENTRIES);

  assign any_locked_o = |(entry_lock_i & MASK);
endmodule

// File: rtl/pmp_seccfg_next.sv
module pmp_seccfg_next
  import pmp_seccfg_pkg::*;
(
  input  seccfg_t          cur_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             locked_i,
  output seccfg_t          nxt_o
);
  always_comb begin
    nxt_o = seccfg_update(cur_i, wdata_i, locked_i);
  end
endmodule

// File: rtl/pmp_seccfg_reg.sv
module pmp_seccfg_reg
  import pmp_seccfg_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int DATA_W    = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [DATA_W-1:0]      wr_data_i,
  input  logic [MAX_ENTRIES-1:0] entry_lock_i,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic                   mml_o,
  output logic                   mmwp_o,
  output logic                   rlb_o,
  output logic                   flush_o
);
  localparam logic HAS_PMP = (N_ENTRIES > 0);
  localparam int   PAD_W   = DATA_W - CFG_W;

  seccfg_t cfg_q, cfg_upd, cfg_d;
  logic    any_locked;
  logic    wr_accept;
  logic    flush_q;
  logic    unused_wdata_hi;

  assign unused_wdata_hi = ^wr_data_i[DATA_W-1:CFG_W];

  pmp_lock_scan #(.N_ENTRIES(N_ENTRIES)) u_scan (
    .entry_lock_i (entry_lock_i),
    .any_locked_o (any_locked)
  );

  pmp_seccfg_next u_next (
    .cur_i    (cfg_q),
    .wdata_i  (wr_data_i[CFG_W-1:0]),
    .locked_i (any_locked),
    .nxt_o    (cfg_upd)
  );

  // Writes are dropped entirely when no protection entry exists.
  assign wr_accept = wr_en_i & HAS_PMP;
  assign cfg_d     = wr_accept ? cfg_upd : cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      flush_q <= wr_accept;
    end
  end

  assign rd_data_o = {{PAD_W{1'b0}}, cfg_q};
  assign mml_o     = cfg_q.mml;
  assign mmwp_o    = cfg_q.mmwp;
  assign rlb_o     = cfg_q.rlb;
  assign flush_o   = flush_q;

  // Assertions next to the logic they guard.
  a_r2_mml_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mml_o |=> mml_o);
  a_r3_mmwp_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mmwp_o |=> mmwp_o);
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable({mml_o, mmwp_o, rlb_o}));
  a_r8_no_flush_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !flush_o);

  generate
    if (HAS_PMP) begin : g_pmp
      a_r5_rlb_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && !rlb_o && any_locked) |=> !rlb_o);
      a_r8_flush_after_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> flush_o);
      a_r2_mml_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_data_i[0]) |=> mml_o);
    end else begin : g_nopmp
      a_r9_stays_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (!mml_o && !mmwp_o && !rlb_o && !flush_o));
    end
  endgenerate
endmodule

// File: tb/pmp_seccfg_reg_tb.sv
module pmp_seccfg_reg_tb;
  localparam int DW = 32;
  localparam int NE = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [15:0]   locks = '0;
  logic [DW-1:0] rd_a, rd_b;
  logic          mml_a, mmwp_a, rlb_a, fl_a;
  logic          mml_b, mmwp_b, rlb_b, fl_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pmp_seccfg_reg #(.N_ENTRIES(NE), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .entry_lock_i(locks), .rd_data_o(rd_a), .mml_o(mml_a), .mmwp_o(mmwp_a),
    .rlb_o(rlb_a), .flush_o(fl_a));

  pmp_seccfg_reg #(.N_ENTRIES(0), .DATA_W(DW)) u_dut_empty (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .entry_lock_i(locks), .rd_data_o(rd_b), .mml_o(mml_b), .mmwp_o(mmwp_b),
    .rlb_o(rlb_b), .flush_o(fl_b));

  typedef struct {
    logic [2:0] st;  // {rlb, mmwp, mml} of the 8-entry instance
    logic       fl;
    string      req;
  } exp_t;

  exp_t        q[$];
  logic [2:0]  m_st = 3'b000;  // bench model: bit0 mml, bit1 mmwp, bit2 rlb

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues what must follow it.
  task automatic drive(input bit we, input logic [DW-1:0] d, input logic [15:0] lk,
                       input string req);
    exp_t e;
    bit   frozen;
    @(negedge clk);
    wr_en = we; wr_data = d; locks = lk;
    #1;
    check(rd_a == {29'd0, m_st}, "R10 read", rd_a, {29'd0, m_st});
    if (we) begin
      frozen = (m_st[2] == 1'b0) && ((lk[NE-1:0]) != '0);
      m_st[0] = m_st[0] || d[0];
      m_st[1] = m_st[1] || d[1];
      if (!frozen) m_st[2] = d[2];
    end
    e.st = m_st; e.fl = we; e.req = req;
    q.push_back(e);
  endtask

  // Monitor: compares after each rising edge.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({rlb_a, mmwp_a, mml_a} == e.st, e.req, {29'd0, rlb_a, mmwp_a, mml_a}, {29'd0, e.st});
      check(fl_a == e.fl, "R8 flush", {31'd0, fl_a}, {31'd0, e.fl});
      check({rlb_b, mmwp_b, mml_b, fl_b} == 4'b0 && rd_b == '0, "R9 empty",
            {27'd0, rlb_b, mmwp_b, mml_b, fl_b}, '0);
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #2;
    check({mml_a, mmwp_a, rlb_a, fl_a} == 4'b0 && rd_a == '0, "R1 reset",
          {28'd0, mml_a, mmwp_a, rlb_a, fl_a}, '0);
    @(negedge clk); rst_n = 1'b1;
    drive(0, '0, '0, "R11 idle");
    drive(1, 32'h4, '0, "R4 rlb set");              // rlb -> 1
    drive(1, 32'h0, '0, "R4 rlb clear");            // rlb -> 0
    drive(1, 32'hFFFF_FF04, 16'hFF00, "R7 high locks ignored"); // rlb -> 1, upper data dropped (R10)
    drive(0, '0, '0, "R8 single pulse");
    drive(1, 32'h0, 16'h0001, "R6 clear while locked");  // rlb 1 -> 0 allowed
    drive(1, 32'h4, 16'h0080, "R5 frozen same-cycle lock");
    drive(1, 32'h4, 16'h0010, "R5 frozen again");
    drive(1, 32'h4, 16'h0000, "R4 unlock releases");     // rlb -> 1
    drive(1, 32'h4, 16'h0001, "R6 keep while locked");
    drive(1, 32'h1, 16'h0000, "R2 mml set");
    drive(1, 32'h0, 16'h0000, "R2 mml sticky");
    drive(1, 32'h2, 16'h0000, "R3 mmwp set");
    drive(1, 32'h0, 16'h0000, "R3 mmwp sticky");
    drive(0, 32'h7, 16'hFFFF, "R11 no write hold");
    drive(1, 32'h4, 16'h0000, "R4 rlb after hold");
    drive(0, '0, '0, "R8 idle after");
    drive(0, '0, '0, "R11 idle");
    @(negedge clk);
    #4;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule